// File: doc/BRIEF.md
# Write-Protect Command Sequence Guard

This block sits in front of the page controller of a parallel EEPROM. It observes every byte write cycle (a one-cycle strobe with a 15-bit address and an 8-bit data byte) and looks for fixed unlock and lock byte sequences. From what it sees, it keeps a protection flag and reports, one cycle after each strobe, one of two outcomes. The byte is either a command byte that was consumed, or a data byte that may or may not be written into the array.

A three-byte prefix does two things. It arms protection, and it opens a write window in which the bytes that follow are stored even while protection is on. A six-byte sequence also opens a window, and it removes protection. The new protection value takes effect when the page controller signals the end of its write period. This happens even if no data byte followed the command. Every write restarts the write cycle, blocked or not.

The protection flag models non-volatile state. The ordinary reset does not clear it. A separate factory-clear input returns it to the unprotected state.

Top module: `wp_guard`

## Requirements
- R1: After factory clear (`fclr_ni` low), `protect_o` is 0. While unprotected, any data byte that is not part of a command produces a `commit_o` pulse.
- R2: The sequence AA@5555, 55@2AAA, A0@5555 (hex data@address, each one strobe) is consumed. When unprotected, the following data bytes commit, and `protect_o` becomes 1 after the next `wp_end_i` pulse.
- R3: While `protect_o` is 1 and no window is open, a data byte produces no `commit_o` pulse, but it still produces a `cyc_start_o` pulse.
- R4: While protected, the three-byte prefix lets the data bytes in that write period commit, and `protect_o` stays 1 after `wp_end_i`.
- R5: The sequence AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 is consumed, and `protect_o` becomes 0 after the next `wp_end_i` pulse.
- R6: `protect_o` changes only on the cycle after a `wp_end_i` pulse (or on factory clear). A command followed directly by `wp_end_i`, with no data byte, still applies.
- R7: Every byte accepted as part of a command produces a `consumed_o` pulse and never a `commit_o` pulse.
- R8: A byte that does not continue a partial sequence aborts the match and is handled as a data byte. If that byte is AA@5555 itself, it is consumed and starts a new match.
- R9: While a write window is open, bytes are not decoded as commands. AA@5555 inside a window commits as data.
- R10: `rst_ni` does not change `protect_o`, but it does clear any partial match and any open window.
- R11: `commit_o`, `consumed_o` and `cyc_start_o` are one-cycle pulses registered one cycle after the strobe. `commit_o` and `consumed_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the decoder, released synchronously |
| fclr_ni | input | 1 | Active-low factory clear of the protection flag |
| wr_stb_i | input | 1 | One-cycle byte write strobe |
| wr_addr_i | input | 15 | Byte address of the write |
| wr_data_i | input | 8 | Data byte of the write |
| wp_end_i | input | 1 | One-cycle pulse at the end of the internal write period |
| protect_o | output | 1 | Protection flag |
| commit_o | output | 1 | Pulse: the last byte may be written into the array |
| consumed_o | output | 1 | Pulse: the last byte was a command byte |
| cyc_start_o | output | 1 | Pulse: the last byte starts or restarts the write cycle |

## Verification
The assertions rely on the page controller behaving in two ways. It never raises `wp_end_i` in the same cycle as `wr_stb_i`, and it never issues strobes on back-to-back cycles. The stimulus respects both: each write is a single-cycle strobe followed by an idle cycle, and end-of-period pulses are issued only between writes. The assertions also treat a change of `protect_o` while factory clear is active as outside their scope. The stimulus applies factory clear only at start-up and in one directed test.

// File: rtl/wp_cmd_pkg.sv
package wp_cmd_pkg;

  typedef enum logic [2:0] {
    M_IDLE,
    M_K1,
    M_K2,
    M_K3,
    M_K4,
    M_K5
  } match_e;

  localparam int unsigned CMD_W = 8;

  localparam logic [CMD_W-1:0] D_KEY1 = 8'hAA;
  localparam logic [CMD_W-1:0] D_KEY2 = 8'h55;
  localparam logic [CMD_W-1:0] D_ARM  = 8'hA0;
  localparam logic [CMD_W-1:0] D_OFF1 = 8'h80;
  localparam logic [CMD_W-1:0] D_OFF2 = 8'h20;

endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_no = sync_q[STAGES-1];

endmodule

// File: rtl/wp_seq_match.sv
module wp_seq_match
  import wp_cmd_pkg::*;
#(
  parameter int unsigned         AW    = 15,
  parameter logic [AW-1:0]       KEY_A = 15'h5555,
  parameter logic [AW-1:0]       KEY_B = 15'h2AAA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             hold_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CMD_W-1:0] data_i,
  output logic             used_o,
  output logic             arm_o,
  output logic             off_o
);

  match_e st_q, st_n;

  logic at_a, at_b, key1, key2;

  assign at_a = (addr_i == KEY_A);
  assign at_b = (addr_i == KEY_B);
  assign key1 = at_a && (data_i == D_KEY1);
  assign key2 = at_b && (data_i == D_KEY2);

  always_comb begin
    st_n   = st_q;
    used_o = 1'b0;
    arm_o  = 1'b0;
    off_o  = 1'b0;
    if (hold_i) begin
      st_n = M_IDLE;
    end else if (stb_i) begin
      // default: break the match, restart on a first key byte
      st_n   = key1 ? M_K1 : M_IDLE;
      used_o = key1;
      unique case (st_q)
        M_K1: if (key2) begin
          st_n = M_K2; used_o = 1'b1;
        end
        M_K2: if (at_a && data_i == D_ARM) begin
          st_n = M_IDLE; used_o = 1'b1; arm_o = 1'b1;
        end else if (at_a && data_i == D_OFF1) begin
          st_n = M_K3; used_o = 1'b1;
        end
        M_K3: if (key1) begin
          st_n = M_K4; used_o = 1'b1;
        end
        M_K4: if (key2) begin
          st_n = M_K5; used_o = 1'b1;
        end
        M_K5: if (at_a && data_i == D_OFF2) begin
          st_n = M_IDLE; used_o = 1'b1; off_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= M_IDLE;
    end else begin
      st_q <= st_n;
    end
  end

endmodule

// File: rtl/wp_prot_state.sv
module wp_prot_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fclr_ni,
  input  logic arm_i,
  input  logic off_i,
  input  logic wp_end_i,
  output logic prot_o,
  output logic win_o
);

  logic win_q, win_n;
  logic pend_q, pend_n;
  logic prot_q;
  logic prot_en;
  logic cmd_hit;

  assign cmd_hit = arm_i || off_i;
  assign prot_en = wp_end_i && win_q;

  always_comb begin
    win_n  = win_q;
    pend_n = pend_q;
    if (cmd_hit) begin
      win_n  = 1'b1;
      pend_n = arm_i;
    end else if (wp_end_i) begin
      win_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      win_q  <= win_n;
      pend_q <= pend_n;
    end
  end

  // non-volatile model: only the factory clear resets it
  always_ff @(posedge clk_i or negedge fclr_ni) begin
    if (!fclr_ni) begin
      prot_q <= 1'b0;
    end else if (prot_en) begin
      prot_q <= pend_q;
    end
  end

  assign prot_o = prot_q;
  assign win_o  = win_q;

endmodule

// File: rtl/wp_out_gate.sv
module wp_out_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic used_i,
  input  logic prot_i,
  input  logic win_i,
  output logic commit_o,
  output logic used_o,
  output logic start_o
);

  logic commit_n, used_n;
  logic commit_q, used_q, start_q;

  always_comb begin
    used_n   = stb_i && used_i;
    commit_n = stb_i && !used_i && (!prot_i || win_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_q <= 1'b0;
      used_q   <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      commit_q <= commit_n;
      used_q   <= used_n;
      start_q  <= stb_i;
    end
  end

  assign commit_o = commit_q;
  assign used_o   = used_q;
  assign start_o  = start_q;

endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_cmd_pkg::*;
#(
  parameter int unsigned   AW    = 15,
  parameter logic [AW-1:0] KEY_A = 15'h5555,
  parameter logic [AW-1:0] KEY_B = 15'h2AAA,
  parameter int unsigned   SYNC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fclr_ni,
  input  logic             wr_stb_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [CMD_W-1:0] wr_data_i,
  input  logic             wp_end_i,
  output logic             protect_o,
  output logic             commit_o,
  output logic             consumed_o,
  output logic             cyc_start_o
);

  localparam int unsigned NRST = 2;

  logic [NRST-1:0] arst_n, srst_n;
  logic used_w, arm_w, off_w, win_q, prot_w;

  assign arst_n = {fclr_ni, rst_ni};

  for (genvar g = 0; g < NRST; g++) begin : g_rsync
    wp_rst_sync #(.STAGES(SYNC)) u_sync (
      .clk_i  (clk_i),
      .arst_ni(arst_n[g]),
      .srst_no(srst_n[g])
    );
  end

  wp_seq_match #(.AW(AW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_match (
    .clk_i (clk_i),
    .rst_ni(srst_n[0]),
    .stb_i (wr_stb_i),
    .hold_i(win_q),
    .addr_i(wr_addr_i),
    .data_i(wr_data_i),
    .used_o(used_w),
    .arm_o (arm_w),
    .off_o (off_w)
  );

  wp_prot_state u_state (
    .clk_i   (clk_i),
    .rst_ni  (srst_n[0]),
    .fclr_ni (srst_n[1]),
    .arm_i   (arm_w),
    .off_i   (off_w),
    .wp_end_i(wp_end_i),
    .prot_o  (prot_w),
    .win_o   (win_q)
  );

  wp_out_gate u_gate (
    .clk_i   (clk_i),
    .rst_ni  (srst_n[0]),
    .stb_i   (wr_stb_i),
    .used_i  (used_w),
    .prot_i  (prot_w),
    .win_i   (win_q),
    .commit_o(commit_o),
    .used_o  (consumed_o),
    .start_o (cyc_start_o)
  );

  assign protect_o = prot_w;

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fclr_ni,
  input logic wr_stb_i,
  input logic wp_end_i,
  input logic win_i,
  input logic protect_o,
  input logic commit_o,
  input logic consumed_o,
  input logic cyc_start_o
);

  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && consumed_o));

  a_r11_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o || consumed_o) |-> $past(wr_stb_i));

  a_r11_start_with_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o || consumed_o) |-> cyc_start_o);

  a_r6_change_on_end: assert property (@(posedge clk_i) disable iff (!rst_ni || !fclr_ni)
    (protect_o != $past(protect_o)) |-> $past(wp_end_i));

  a_r3_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni || !fclr_ni)
    commit_o |-> ($past(!protect_o) || $past(win_i)));

  a_r9_no_decode_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i && wr_stb_i) |=> !consumed_o);

endmodule

bind wp_guard wp_guard_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fclr_ni    (fclr_ni),
  .wr_stb_i   (wr_stb_i),
  .wp_end_i   (wp_end_i),
  .win_i      (win_q),
  .protect_o  (protect_o),
  .commit_o   (commit_o),
  .consumed_o (consumed_o),
  .cyc_start_o(cyc_start_o)
);

// File: tb/wp_guard_tb_top.sv
module wp_guard_tb_top;

  logic        clk = 1'b0;
  logic        rst_n, fclr_n, stb, wp_end;
  logic [14:0] addr;
  logic [7:0]  data;
  logic        protect, commit, consumed, cstart;
  int          errors = 0;
  int          checks = 0;

  always #2 clk = ~clk;

  wp_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fclr_ni(fclr_n),
    .wr_stb_i(stb), .wr_addr_i(addr), .wr_data_i(data), .wp_end_i(wp_end),
    .protect_o(protect), .commit_o(commit), .consumed_o(consumed),
    .cyc_start_o(cstart)
  );

  // {end_after, exp_commit, exp_consumed, exp_protect, addr, data}
  localparam int NV = 25;
  localparam logic [26:0] VEC [NV] = '{
    {4'b0100, 15'h0123, 8'h5A},  // R1 plain data, unprotected
    {4'b0010, 15'h5555, 8'hAA},  // R2 R7
    {4'b0010, 15'h2AAA, 8'h55},
    {4'b0010, 15'h5555, 8'hA0},
    {4'b1101, 15'h0040, 8'h11},  // R2 data after prefix, then end
    {4'b0001, 15'h0041, 8'h22},  // R3 blocked
    {4'b0011, 15'h5555, 8'hAA},
    {4'b0011, 15'h2AAA, 8'h55},
    {4'b0001, 15'h1234, 8'h33},  // R8 break -> blocked data
    {4'b0011, 15'h5555, 8'hAA},  // R4
    {4'b0011, 15'h2AAA, 8'h55},
    {4'b0011, 15'h5555, 8'hA0},
    {4'b1101, 15'h0050, 8'h44},  // R4 commit, stays protected
    {4'b0011, 15'h5555, 8'hAA},
    {4'b0011, 15'h5555, 8'hAA},  // R8 restart on key byte
    {4'b0011, 15'h2AAA, 8'h55},  // R5
    {4'b0011, 15'h5555, 8'h80},
    {4'b0011, 15'h5555, 8'hAA},
    {4'b0011, 15'h2AAA, 8'h55},
    {4'b1010, 15'h5555, 8'h20},  // R5 R6 end with no data
    {4'b0100, 15'h0060, 8'h55},  // R5 unprotected again
    {4'b0100, 15'h5555, 8'hA0},  // R8 lone third byte is data
    {4'b0010, 15'h5555, 8'hAA},
    {4'b0010, 15'h2AAA, 8'h55},
    {4'b1011, 15'h5555, 8'hA0}   // R6 arm with no data
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    stb = 1'b1; addr = a; data = d;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic do_end();
    @(negedge clk);
    wp_end = 1'b1;
    @(negedge clk);
    wp_end = 1'b0;
  endtask

  task automatic wr_chk(input string req, input logic [14:0] a, input logic [7:0] d,
                        input logic ec, input logic eu);
    do_wr(a, d);
    chk({req, " commit"}, commit, ec);
    chk({req, " consumed"}, consumed, eu);
    chk({req, " start"}, cstart, 1'b1);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; fclr_n = 1'b0; stb = 1'b0; wp_end = 1'b0;
    addr = '0; data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1; fclr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset protect", protect, 1'b0);
    chk("R11 reset commit", commit, 1'b0);
    chk("R11 reset consumed", consumed, 1'b0);

    for (int i = 0; i < NV; i++) begin
      do_wr(VEC[i][22:8], VEC[i][7:0]);
      chk($sformatf("R7 R11 vec%0d commit", i), commit, VEC[i][25]);
      chk($sformatf("R7 R11 vec%0d consumed", i), consumed, VEC[i][24]);
      chk($sformatf("R3 vec%0d start", i), cstart, 1'b1);
      if (VEC[i][26]) do_end();
      @(negedge clk);
      chk($sformatf("R6 vec%0d protect", i), protect, VEC[i][23]);
    end

    // R10: reset keeps protection
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 protect after reset", protect, 1'b1);
    wr_chk("R3 blocked", 15'h0070, 8'h66, 1'b0, 1'b0);

    // R9: key byte inside a window is data
    wr_chk("R4 k1", 15'h5555, 8'hAA, 1'b0, 1'b1);
    wr_chk("R4 k2", 15'h2AAA, 8'h55, 1'b0, 1'b1);
    wr_chk("R4 k3", 15'h5555, 8'hA0, 1'b0, 1'b1);
    wr_chk("R9 key in window", 15'h5555, 8'hAA, 1'b1, 1'b0);
    wr_chk("R9 key2 in window", 15'h2AAA, 8'h55, 1'b1, 1'b0);
    do_end();
    chk("R4 protect kept", protect, 1'b1);

    // R10: reset drops a partial match
    wr_chk("R10 k1", 15'h5555, 8'hAA, 1'b0, 1'b1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wr_chk("R10 partial lost", 15'h2AAA, 8'h55, 1'b0, 1'b0);

    // R1: factory clear
    fclr_n = 1'b0;
    repeat (2) @(negedge clk);
    fclr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 factory clear", protect, 1'b0);
    wr_chk("R1 data after clear", 15'h0080, 8'h77, 1'b1, 1'b0);

    finish_run();
  end

endmodule